// File: doc/BRIEF.md
# Weighted Cluster Centroid Finder

The block watches a single 8-bit word bus that carries channel hits as pairs: first the number of a channel, then the amplitude read from it. It groups hits on consecutive channel numbers into clusters of up to four channels. For each cluster it returns one 8-bit channel number that marks the amplitude-weighted centre of the cluster.

Each amplitude is cut to its six upper bits before it is used as a weight. Inside a cluster every channel is known only by its 2-bit distance from the first channel. Two running sums build up: the weights times those distances, and the weights alone. When the cluster closes, both sums are latched together and passed to a divider. The divider reads a reciprocal from a table computed at elaboration, multiplies, and rounds down. The first channel number of the cluster is then added back to give the full address. Results leave the block in the order the clusters closed, each marked by a one-cycle strobe.

A cluster closes in three cases: the next hit is not on the next channel number, a fifth channel would join it, or the end-of-event input is raised. A hit that does not continue the open cluster starts a new cluster.

Top module: `cluster_centroid`

## Requirements
- R1: Words with `in_valid` high alternate between a channel number and an amplitude. After reset, and after any word or idle cycle with `end_evt` high, the next word is taken as a channel number. Idle cycles between words do not disturb this pairing.
- R2: The weight of a hit is the upper six bits of its amplitude (bits 7 down to 2). The two low amplitude bits never change a result.
- R3: A hit continues the open cluster only when its channel number is exactly one above the last channel of the cluster. No wrap is allowed, so 255 is never followed by 0. Any other hit closes the open cluster and starts a new one.
- R4: A cluster holds at most four channels. An adjacent fifth hit closes the four-channel cluster and starts a new one.
- R5: `end_evt` closes the open cluster after including a hit whose amplitude word arrives in the same cycle. If that hit also closed an earlier cluster, both results are produced, the earlier one first.
- R6: The centroid equals the first channel plus floor(sum(distance × weight) / sum(weight)), where distance is 0 to 3 from the first channel.
- R7: A cluster whose weights are all zero reports its first channel number.
- R8: Each cluster gives exactly one `centroid_valid` pulse, in closing order. `centroid_addr` keeps its value while `centroid_valid` is low.
- R9: During and right after reset, `centroid_valid` is low and `centroid_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is present on `in_word` this cycle |
| in_word | input | 8 | Channel number or amplitude, alternating |
| end_evt | input | 1 | Close the open cluster and expect a channel number next |
| centroid_addr | output | 8 | Weighted centre of the last closed cluster |
| centroid_valid | output | 1 | One-cycle strobe for a new `centroid_addr` |

## Verification
The hardest case to reach from the ports is two closes in a single cycle. This happens when a hit breaks adjacency and, in the same cycle, its amplitude word carries `end_evt`. The older cluster and the new one-channel cluster must then both come out, in order. The bench drives that exact pairing on purpose. It also drives a run of five adjacent hits, a 255-to-0 step, and idle gaps between the two words of a pair. A pseudo-random run of mostly adjacent hits checks the divider rounding against a plain integer division done in the bench.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } word_phase_e;

    // Rounded-up reciprocal 2^shift / den. Used to fill the divider table.
    function automatic int unsigned recip_entry(int unsigned den, int unsigned shift);
        int unsigned one;
        one = 32'd1 << shift;
        if (den == 0) begin
            return 0;
        end
        return (one + den - 1) / den;
    endfunction

endpackage

// File: rtl/ccf_demux.sv
module ccf_demux #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              end_evt,
    output logic              pair_valid,
    output logic [WORD_W-1:0] pair_addr,
    output logic [WORD_W-1:0] pair_data,
    output logic              pair_close
);
    import ccf_pkg::*;

    typedef struct packed {
        word_phase_e       phase;
        logic [WORD_W-1:0] addr_hold;
        logic              pv;
        logic [WORD_W-1:0] pa;
        logic [WORD_W-1:0] pd;
        logic              pc;
    } dmx_state_t;

    dmx_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.pv = 1'b0;
        st_d.pc = end_evt;
        if (in_valid) begin
            if (st_q.phase == PH_ADDR) begin
                st_d.addr_hold = in_word;
                st_d.phase     = PH_DATA;
            end else begin
                st_d.pv    = 1'b1;
                st_d.pa    = st_q.addr_hold;
                st_d.pd    = in_word;
                st_d.phase = PH_ADDR;
            end
        end
        if (end_evt) begin
            st_d.phase = PH_ADDR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_valid = st_q.pv;
    assign pair_addr  = st_q.pa;
    assign pair_data  = st_q.pd;
    assign pair_close = st_q.pc;

    // R1: a complete pair needs two words, so pairs never come back to back
    assert_pair_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

endmodule

// File: rtl/ccf_cluster.sv
module ccf_cluster #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int WEIGHT_W = 6,
    parameter int MAX_SPAN = 4,
    parameter int OFS_W    = $clog2(MAX_SPAN),
    parameter int DSUM_W   = WEIGHT_W + OFS_W,
    parameter int NSUM_W   = WEIGHT_W + 2 * OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_valid,
    input  logic [ADDR_W-1:0] pair_addr,
    input  logic [DATA_W-1:0] pair_data,
    input  logic              pair_close,
    output logic              close_valid,
    output logic [ADDR_W-1:0] close_base,
    output logic [NSUM_W-1:0] close_num,
    output logic [DSUM_W-1:0] close_den
);
    localparam int CNT_W   = $clog2(MAX_SPAN + 1);
    localparam int MAX_DEN = MAX_SPAN * ((1 << WEIGHT_W) - 1);

    typedef struct packed {
        logic              active;
        logic              pend;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] last;
        logic [CNT_W-1:0]  cnt;
        logic [NSUM_W-1:0] num;
        logic [DSUM_W-1:0] den;
        logic              cv;
        logic [ADDR_W-1:0] cb;
        logic [NSUM_W-1:0] cn;
        logic [DSUM_W-1:0] cd;
    } clu_state_t;

    clu_state_t st_d, st_q;
    logic [WEIGHT_W-1:0] weight;
    logic                adjacent;

    always_comb begin
        weight   = pair_data[DATA_W-1 -: WEIGHT_W];
        adjacent = st_q.active
                && (st_q.last != {ADDR_W{1'b1}})
                && (pair_addr == st_q.last + ADDR_W'(1))
                && (st_q.cnt < CNT_W'(MAX_SPAN));

        st_d    = st_q;
        st_d.cv = 1'b0;

        // deferred close of a one-hit cluster opened in the previous cycle
        if (st_q.pend) begin
            st_d.cv     = 1'b1;
            st_d.cb     = st_q.base;
            st_d.cn     = st_q.num;
            st_d.cd     = st_q.den;
            st_d.active = 1'b0;
            st_d.pend   = 1'b0;
        end

        if (pair_valid) begin
            if (adjacent) begin
                st_d.num  = st_q.num + NSUM_W'(st_q.cnt[OFS_W-1:0]) * NSUM_W'(weight);
                st_d.den  = st_q.den + DSUM_W'(weight);
                st_d.cnt  = st_q.cnt + CNT_W'(1);
                st_d.last = pair_addr;
            end else begin
                if (st_q.active) begin
                    st_d.cv = 1'b1;
                    st_d.cb = st_q.base;
                    st_d.cn = st_q.num;
                    st_d.cd = st_q.den;
                end
                st_d.active = 1'b1;
                st_d.base   = pair_addr;
                st_d.last   = pair_addr;
                st_d.cnt    = CNT_W'(1);
                st_d.num    = '0;
                st_d.den    = DSUM_W'(weight);
            end
        end

        if (pair_close && st_d.active) begin
            if (st_d.cv) begin
                st_d.pend = 1'b1;
            end else begin
                st_d.cv     = 1'b1;
                st_d.cb     = st_d.base;
                st_d.cn     = st_d.num;
                st_d.cd     = st_d.den;
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign close_valid = st_q.cv;
    assign close_base  = st_q.cb;
    assign close_num   = st_q.cn;
    assign close_den   = st_q.cd;

    // R4: an open cluster always holds between one and MAX_SPAN hits
    assert_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cnt >= CNT_W'(1)) && (st_q.cnt <= CNT_W'(MAX_SPAN)));

    // R2: the weight sum never exceeds what MAX_SPAN six-bit weights can give
    assert_den_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (int'(st_q.den) <= MAX_DEN));

    // R5: a deferred close never meets a new pair and is cleared the next cycle
    assert_pend_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> !pair_valid);
    assert_pend_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> (!st_q.pend && close_valid));

endmodule

// File: rtl/ccf_divide.sv
module ccf_divide #(
    parameter int ADDR_W   = 8,
    parameter int MAX_SPAN = 4,
    parameter int OFS_W    = 2,
    parameter int NSUM_W   = 10,
    parameter int DSUM_W   = 8,
    parameter int SHIFT    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close_valid,
    input  logic [ADDR_W-1:0] close_base,
    input  logic [NSUM_W-1:0] close_num,
    input  logic [DSUM_W-1:0] close_den,
    output logic [ADDR_W-1:0] centroid_addr,
    output logic              centroid_valid
);
    localparam int RW     = SHIFT + 1;
    localparam int DEPTH  = 1 << DSUM_W;
    localparam int PROD_W = NSUM_W + RW;

    logic [RW-1:0] recip_rom [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_recip
        assign recip_rom[gi] = RW'(ccf_pkg::recip_entry(gi, SHIFT));
    end

    typedef struct packed {
        logic              s1v;
        logic              zero;
        logic [ADDR_W-1:0] base;
        logic [NSUM_W-1:0] num;
        logic [RW-1:0]     recip;
        logic              ov;
        logic [ADDR_W-1:0] oaddr;
    } div_state_t;

    div_state_t      st_d, st_q;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] q_raw;
    logic [OFS_W-1:0]  q_lim;

    always_comb begin
        prod  = PROD_W'(st_q.num) * PROD_W'(st_q.recip);
        q_raw = prod >> SHIFT;
        q_lim = (q_raw > PROD_W'(MAX_SPAN - 1)) ? OFS_W'(MAX_SPAN - 1) : q_raw[OFS_W-1:0];

        st_d     = st_q;
        st_d.s1v = close_valid;
        if (close_valid) begin
            st_d.zero  = (close_den == '0);
            st_d.base  = close_base;
            st_d.num   = close_num;
            st_d.recip = recip_rom[close_den];
        end

        st_d.ov = st_q.s1v;
        if (st_q.s1v) begin
            st_d.oaddr = st_q.zero ? st_q.base : st_q.base + ADDR_W'(q_lim);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign centroid_addr  = st_q.oaddr;
    assign centroid_valid = st_q.ov;

    // R6: a weighted mean of distances never lies past the last possible distance
    assert_quot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1v |-> (q_raw <= PROD_W'(MAX_SPAN - 1)));

    // R8: each latched close gives exactly one output strobe two cycles later
    assert_close_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        close_valid |=> st_q.s1v);
    assert_strobe_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1v |=> centroid_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !centroid_valid |-> $stable(centroid_addr));

endmodule

// File: rtl/cluster_centroid.sv
module cluster_centroid #(
    parameter int ADDR_W   = 8,
    parameter int WEIGHT_W = 6,
    parameter int MAX_SPAN = 4,
    parameter int SHIFT    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_word,
    input  logic              end_evt,
    output logic [ADDR_W-1:0] centroid_addr,
    output logic              centroid_valid
);
    localparam int OFS_W  = $clog2(MAX_SPAN);
    localparam int DSUM_W = WEIGHT_W + OFS_W;
    localparam int NSUM_W = WEIGHT_W + 2 * OFS_W;

    logic              pair_valid;
    logic [ADDR_W-1:0] pair_addr;
    logic [ADDR_W-1:0] pair_data;
    logic              pair_close;
    logic              close_valid;
    logic [ADDR_W-1:0] close_base;
    logic [NSUM_W-1:0] close_num;
    logic [DSUM_W-1:0] close_den;

    ccf_demux #(
        .WORD_W (ADDR_W)
    ) u_demux (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .end_evt    (end_evt),
        .pair_valid (pair_valid),
        .pair_addr  (pair_addr),
        .pair_data  (pair_data),
        .pair_close (pair_close)
    );

    ccf_cluster #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (ADDR_W),
        .WEIGHT_W (WEIGHT_W),
        .MAX_SPAN (MAX_SPAN),
        .OFS_W    (OFS_W),
        .DSUM_W   (DSUM_W),
        .NSUM_W   (NSUM_W)
    ) u_cluster (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_valid  (pair_valid),
        .pair_addr   (pair_addr),
        .pair_data   (pair_data),
        .pair_close  (pair_close),
        .close_valid (close_valid),
        .close_base  (close_base),
        .close_num   (close_num),
        .close_den   (close_den)
    );

    ccf_divide #(
        .ADDR_W   (ADDR_W),
        .MAX_SPAN (MAX_SPAN),
        .OFS_W    (OFS_W),
        .NSUM_W   (NSUM_W),
        .DSUM_W   (DSUM_W),
        .SHIFT    (SHIFT)
    ) u_divide (
        .clk            (clk),
        .rst_n          (rst_n),
        .close_valid    (close_valid),
        .close_base     (close_base),
        .close_num      (close_num),
        .close_den      (close_den),
        .centroid_addr  (centroid_addr),
        .centroid_valid (centroid_valid)
    );

    // R9: reset leaves the output quiet
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!centroid_valid && (centroid_addr == '0)));

endmodule

// File: tb/tb_cluster_centroid.sv
`timescale 1ns/1ps
module tb_cluster_centroid;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_word = 8'd0;
    logic       end_evt = 1'b0;
    logic [7:0] centroid_addr;
    logic       centroid_valid;

    cluster_centroid dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_word        (in_word),
        .end_evt        (end_evt),
        .centroid_addr  (centroid_addr),
        .centroid_valid (centroid_valid)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    string cur_tag = "R6";

    // bench model of the cluster builder
    bit m_active = 1'b0;
    int m_base, m_last, m_cnt, m_num, m_den;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task model_close();
        if (m_active) begin
            exp_q.push_back(m_den == 0 ? m_base : m_base + m_num / m_den);
            tag_q.push_back(cur_tag);
            m_active = 1'b0;
        end
    endtask

    task model_pair(input int a, input int d);
        int w;
        w = d >> 2;
        if (m_active && m_last != 255 && a == m_last + 1 && m_cnt < 4) begin
            m_num  += m_cnt * w;
            m_den  += w;
            m_cnt++;
            m_last = a;
        end else begin
            model_close();
            m_active = 1'b1;
            m_base = a; m_last = a; m_cnt = 1; m_num = 0; m_den = w;
        end
    endtask

    task put_word(input logic [7:0] w, input logic e);
        in_valid = 1'b1;
        in_word  = w;
        end_evt  = e;
        @(posedge clk); #1;
    endtask

    task idle(input int n);
        in_valid = 1'b0;
        end_evt  = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task pair(input int a, input int d, input logic e);
        put_word(8'(a), 1'b0);
        put_word(8'(d), e);
        model_pair(a, d);
        if (e) model_close();
    endtask

    task close_evt();
        in_valid = 1'b0;
        end_evt  = 1'b1;
        @(posedge clk); #1;
        end_evt  = 1'b0;
        model_close();
    endtask

    // monitor: scoreboard compare and hold check
    logic [7:0] prev_addr = 8'd0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (centroid_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected result", int'(centroid_addr), -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(centroid_addr) == e, t, int'(centroid_addr), e);
                end
            end else if (centroid_addr != prev_addr) begin
                check(1'b0, "R8 hold", int'(centroid_addr), int'(prev_addr));
            end
            prev_addr = centroid_addr;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [15:0] lf;
        int        a;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!centroid_valid, "R9 valid in reset", int'(centroid_valid), 0);
        check(centroid_addr == 8'd0, "R9 addr in reset", int'(centroid_addr), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!centroid_valid && centroid_addr == 8'd0, "R9 after reset", int'(centroid_addr), 0);
        @(posedge clk); #1;

        cur_tag = "R6 single";
        pair(10, 8'h80, 1'b1);
        idle(3);

        cur_tag = "R6 four wide";
        pair(40, 40, 1'b0); pair(41, 80, 1'b0); pair(42, 120, 1'b0); pair(43, 160, 1'b1);
        idle(3);

        cur_tag = "R2 low bits";
        pair(30, 3, 1'b0); pair(31, 3, 1'b0); pair(32, 160, 1'b1);
        idle(3);

        cur_tag = "R7 zero weight";
        pair(70, 3, 1'b0); pair(71, 2, 1'b0); close_evt();
        idle(3);

        cur_tag = "R4 fifth";
        pair(50, 64, 1'b0); pair(51, 64, 1'b0); pair(52, 64, 1'b0); pair(53, 64, 1'b0);
        pair(54, 64, 1'b0); close_evt();
        idle(3);

        cur_tag = "R3 gap";
        pair(60, 200, 1'b0); pair(62, 100, 1'b0); pair(63, 255, 1'b0); close_evt();
        idle(3);

        cur_tag = "R3 wrap";
        pair(254, 10, 1'b0); pair(255, 250, 1'b0); pair(0, 200, 1'b0); close_evt();
        idle(3);

        cur_tag = "R5 double close";
        pair(80, 100, 1'b0); pair(81, 100, 1'b0); pair(90, 60, 1'b1);
        idle(4);

        cur_tag = "R1 idle gaps";
        put_word(8'd120, 1'b0); idle(2); put_word(8'd20, 1'b0); model_pair(120, 20);
        idle(1);
        put_word(8'd121, 1'b0); idle(3); put_word(8'd240, 1'b0); model_pair(121, 240);
        close_evt();
        idle(3);

        cur_tag = "R6 random";
        lf = 16'hACE1;
        a  = 100;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a  = a + ((lf[1:0] == 2'b00) ? 2 : 1);
            pair(a, int'(lf[15:8]), 1'b0);
            if (lf[4:2] == 3'b000) idle(1);
        end
        close_evt();
        idle(10);

        check(exp_q.size() == 0, "R8 missing results", exp_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule